// File: doc/BRIEF.md
# DRAM Bank Open-Row Tracker

This block follows the commands that a memory controller places on its DRAM command bus and keeps, for every bank, a record of whether that bank's row buffer is open and which row it holds. The scheduler uses this record to choose between a row hit and a row miss. It does not check whether a command is legal or whether its timing is correct. It records the effect of each command that it is given.

One command arrives per cycle, marked by a valid strobe. An activate opens a bank and stores the row address that comes with it. A precharge closes one bank, and a precharge-all closes every bank in the same cycle. What a refresh closes depends on a static configuration input: with per-bank refresh selected it closes only the bank it names, and otherwise it closes all banks. Read, write and idle codes leave the state alone. Each change takes effect on the clock edge at which the command is sampled. The open flags of all banks are visible at once. The stored row of any one bank is read through a combinational bank-select port.

Top module: `bank_row_tracker`

## Requirements
- R1: While reset is low, and after it is released with no command issued, every open flag is 0 and the selected row output is 0 for every bank.
- R2: A valid command with code 3'd1 (activate) sets the open flag of bank `cmd_bank` and stores `cmd_row` as its row. Both are visible after the rising edge at which the command is sampled, and not before that edge.
- R3: An activate to a bank that is already open replaces the stored row with the new address, and the bank stays open.
- R4: A valid command with code 3'd2 (precharge) clears the open flag of bank `cmd_bank` only. Every other bank keeps its flag and its row.
- R5: A valid command with code 3'd3 (precharge-all) clears the open flag of every bank in one cycle.
- R6: A valid command with code 3'd4 (refresh) while `refresh_per_bank` is 1 clears only the open flag of bank `cmd_bank`.
- R7: A valid command with code 3'd4 (refresh) while `refresh_per_bank` is 0 clears the open flag of every bank.
- R8: Codes 3'd0 (idle), 3'd5 (read), 3'd6 (write) and 3'd7 (reserved) change no open flag and no stored row.
- R9: While `cmd_valid` is 0, no flag or row changes, whatever the code, bank and row inputs carry.
- R10: `sel_open` equals the open flag of bank `sel_bank`. `sel_row` is that bank's stored row when it is open and 0 when it is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present in this cycle |
| cmd_code | input | 3 | Command code (see requirements) |
| cmd_bank | input | BANK_W (3) | Bank the command addresses |
| cmd_row | input | ROW_W (14) | Row address carried by an activate |
| refresh_per_bank | input | 1 | 1: refresh closes one bank; 0: refresh closes all banks |
| open_flags | output | NUM_BANKS (8) | Open flag of each bank, bit i for bank i |
| sel_bank | input | BANK_W (3) | Bank chosen for readout |
| sel_open | output | 1 | Open flag of the chosen bank |
| sel_row | output | ROW_W (14) | Row held by the chosen bank, 0 if it is closed |

## Verification
The assertions expect `refresh_per_bank` to be held steady across a refresh command and its following edge. They expect `cmd_bank` to name a real bank, which holds for any power-of-two bank count. The stimulus changes the configuration bit only while no command is valid. It drives every input at the falling edge, so each command meets exactly one rising edge. The assertions make no assumption about whether commands are legal, for example an activate to an open bank or a precharge to a closed one. The stimulus sends such commands on purpose, so that the tracker is shown to record them without judging them.

// File: rtl/brt_pkg.sv
package brt_pkg;

   typedef enum logic [2:0] {
      BRT_IDLE  = 3'd0,
      BRT_OPEN  = 3'd1,
      BRT_SHUT  = 3'd2,
      BRT_SHUTX = 3'd3,
      BRT_RFSH  = 3'd4,
      BRT_RD    = 3'd5,
      BRT_WR    = 3'd6,
      BRT_RSVD  = 3'd7
   } brt_cmd_e;

   localparam int unsigned BRT_CODE_W = 3;

endpackage

// File: rtl/brt_decode.sv
module brt_decode
   import brt_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned BANK_W    = 3
) (
   input  logic                    cmd_valid,
   input  logic [BRT_CODE_W-1:0]   cmd_code,
   input  logic [BANK_W-1:0]       cmd_bank,
   input  logic                    refresh_per_bank,
   output logic [NUM_BANKS-1:0]    act_vec,
   output logic [NUM_BANKS-1:0]    close_vec
);

   brt_cmd_e code;
   logic     is_act;
   logic     close_one;
   logic     close_all;

   always_comb begin
      code      = brt_cmd_e'(cmd_code);
      is_act    = 1'b0;
      close_one = 1'b0;
      close_all = 1'b0;
      if (cmd_valid) begin
         case (code)
            BRT_OPEN:  is_act    = 1'b1;
            BRT_SHUT:  close_one = 1'b1;
            BRT_SHUTX: close_all = 1'b1;
            BRT_RFSH: begin
               close_one = refresh_per_bank;
               close_all = !refresh_per_bank;
            end
            default: ;
         endcase
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit          = (cmd_bank == BANK_W'(b));
      assign act_vec[b]   = is_act && hit;
      assign close_vec[b] = close_all || (close_one && hit);
   end

endmodule

// File: rtl/brt_bank_slot.sv
module brt_bank_slot #(
   parameter int unsigned ROW_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_en,
   input  logic             close_en,
   input  logic [ROW_W-1:0] row_in,
   output logic             open_q,
   output logic [ROW_W-1:0] row_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (act_en) begin
         open_q <= 1'b1;
         row_q  <= row_in;
      end else if (close_en) begin
         open_q <= 1'b0;
      end
   end

   // R2 and R3: an activate opens the slot and stores the new row.
   a_r2_act_loads: assert property (@(posedge clk) disable iff (!rst_n)
      act_en |=> (open_q && row_q == $past(row_in)));

   // R4: a close leaves the stored row where it was.
   a_r4_close_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
      (close_en && !act_en) |=> (!open_q && $stable(row_q)));

endmodule

// File: rtl/brt_read_mux.sv
module brt_read_mux #(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned BANK_W    = 3,
   parameter int unsigned ROW_W     = 14
) (
   input  logic [NUM_BANKS-1:0]            open_flags,
   input  logic [NUM_BANKS-1:0][ROW_W-1:0] rows,
   input  logic [BANK_W-1:0]               sel_bank,
   output logic                            sel_open,
   output logic [ROW_W-1:0]                sel_row
);

   always_comb begin
      sel_open = open_flags[sel_bank];
      sel_row  = sel_open ? rows[sel_bank] : '0;
   end

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
   import brt_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned ROW_W     = 14,
   localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic [BRT_CODE_W-1:0] cmd_code,
   input  logic [BANK_W-1:0]     cmd_bank,
   input  logic [ROW_W-1:0]      cmd_row,
   input  logic                  refresh_per_bank,
   output logic [NUM_BANKS-1:0]  open_flags,
   input  logic [BANK_W-1:0]     sel_bank,
   output logic                  sel_open,
   output logic [ROW_W-1:0]      sel_row
);

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("bank_row_tracker: NUM_BANKS must be a power of two, at least 2");
   end
   if (ROW_W < 1 || ROW_W > 32) begin : g_bad_row
      $error("bank_row_tracker: ROW_W must lie between 1 and 32");
   end

   logic [NUM_BANKS-1:0]            act_vec;
   logic [NUM_BANKS-1:0]            close_vec;
   logic [NUM_BANKS-1:0][ROW_W-1:0] rows;

   brt_decode #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W)
   ) i_decode (
      .cmd_valid        (cmd_valid),
      .cmd_code         (cmd_code),
      .cmd_bank         (cmd_bank),
      .refresh_per_bank (refresh_per_bank),
      .act_vec          (act_vec),
      .close_vec        (close_vec)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
      brt_bank_slot #(
         .ROW_W (ROW_W)
      ) i_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .act_en   (act_vec[b]),
         .close_en (close_vec[b]),
         .row_in   (cmd_row),
         .open_q   (open_flags[b]),
         .row_q    (rows[b])
      );
   end

   brt_read_mux #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .ROW_W     (ROW_W)
   ) i_mux (
      .open_flags (open_flags),
      .rows       (rows),
      .sel_bank   (sel_bank),
      .sel_open   (sel_open),
      .sel_row    (sel_row)
   );

   logic is_pre, is_prea, is_ref, is_quiet;
   assign is_pre   = cmd_valid && cmd_code == BRT_SHUT;
   assign is_prea  = cmd_valid && cmd_code == BRT_SHUTX;
   assign is_ref   = cmd_valid && cmd_code == BRT_RFSH;
   assign is_quiet = !cmd_valid || cmd_code == BRT_IDLE || cmd_code == BRT_RD
                     || cmd_code == BRT_WR || cmd_code == BRT_RSVD;

   a_r4_pre_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |=> (!open_flags[$past(cmd_bank)]
                  && (((open_flags ^ $past(open_flags))
                       & ~(NUM_BANKS'(1) << $past(cmd_bank))) == '0)));

   a_r5_prea_all: assert property (@(posedge clk) disable iff (!rst_n)
      is_prea |=> (open_flags == '0));

   a_r6_ref_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ref && refresh_per_bank) |=> (!open_flags[$past(cmd_bank)]
                  && (((open_flags ^ $past(open_flags))
                       & ~(NUM_BANKS'(1) << $past(cmd_bank))) == '0)));

   a_r7_ref_all: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ref && !refresh_per_bank) |=> (open_flags == '0));

   a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && is_quiet) |=> $stable(open_flags));

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(open_flags));

   a_r10_sel_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_open == open_flags[sel_bank]) && (sel_open || sel_row == '0));

endmodule

// File: tb/test_bank_row_tracker.sv
`timescale 1ns/1ps
module test_bank_row_tracker;

   localparam int NB = 8;
   localparam int RW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_code = 3'd0;
   logic [2:0]    cmd_bank = 3'd0;
   logic [RW-1:0] cmd_row = '0;
   logic          refresh_per_bank = 1'b0;
   logic [NB-1:0] open_flags;
   logic [2:0]    sel_bank = 3'd0;
   logic          sel_open;
   logic [RW-1:0] sel_row;

   int n_vec = 0;
   int n_bad = 0;
   logic          exp_open [NB];
   logic [RW-1:0] exp_row  [NB];

   always #2.5 clk = ~clk;

   bank_row_tracker i_bank_row_tracker (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_code (cmd_code),
      .cmd_bank (cmd_bank), .cmd_row (cmd_row), .refresh_per_bank (refresh_per_bank),
      .open_flags (open_flags), .sel_bank (sel_bank), .sel_open (sel_open),
      .sel_row (sel_row)
   );

   task automatic check(string req, int b, logic [RW:0] act, logic [RW:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s bank %0d: actual %h expected %h", req, b, act, exp);
      end
   endtask

   // Sweep the readout port over every bank, comparing with the model.
   task automatic check_all(string req);
      for (int b = 0; b < NB; b++) begin
         sel_bank = 3'(b);
         #0.1;
         check(req, b, {sel_open, sel_row},
               {exp_open[b], exp_open[b] ? exp_row[b] : {RW{1'b0}}});
         check(req, b, {{RW{1'b0}}, open_flags[b]}, {{RW{1'b0}}, exp_open[b]});
      end
   endtask

   task automatic model(logic [2:0] code, int b, logic [RW-1:0] row);
      case (code)
         3'd1: begin exp_open[b] = 1'b1; exp_row[b] = row; end
         3'd2: exp_open[b] = 1'b0;
         3'd3: for (int k = 0; k < NB; k++) exp_open[k] = 1'b0;
         3'd4: if (refresh_per_bank) exp_open[b] = 1'b0;
               else for (int k = 0; k < NB; k++) exp_open[k] = 1'b0;
         default: ;
      endcase
   endtask

   // Drive at a falling edge; one rising edge passes before the next one.
   task automatic issue(logic [2:0] code, int b, logic [RW-1:0] row);
      cmd_valid = 1'b1; cmd_code = code; cmd_bank = 3'(b); cmd_row = row;
      model(code, b, row);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_code = 3'd0; cmd_row = '0;
   endtask

   task automatic t_reset;
      for (int b = 0; b < NB; b++) begin exp_open[b] = 1'b0; exp_row[b] = '0; end
      check_all("R1 in reset");
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after reset");
   endtask

   task automatic t_activate;
      // Before the edge nothing may show.
      cmd_valid = 1'b1; cmd_code = 3'd1; cmd_bank = 3'd2; cmd_row = 14'h1A5;
      sel_bank = 3'd2; #0.5;
      check("R2 before edge", 2, {sel_open, sel_row}, {1'b0, {RW{1'b0}}});
      model(3'd1, 2, 14'h1A5);
      @(negedge clk); cmd_valid = 1'b0;
      check_all("R2 one activate");
      issue(3'd1, 0, 14'h3FFF);
      issue(3'd1, 7, 14'h0001);
      issue(3'd1, 5, 14'h2222);
      check_all("R2 several banks");
   endtask

   task automatic t_reactivate;
      issue(3'd1, 2, 14'h0BEE);
      check_all("R3 row replaced");
   endtask

   task automatic t_precharge;
      issue(3'd2, 5, 14'h3333);
      check_all("R4 single precharge");
      issue(3'd2, 4, 14'h0);
      check_all("R4 precharge closed bank");
   endtask

   task automatic t_prea;
      issue(3'd3, 1, 14'h0);
      check_all("R5 precharge all");
      issue(3'd1, 3, 14'h0777);
      check_all("R5 reopen after all");
   endtask

   task automatic t_ref;
      issue(3'd1, 6, 14'h1111);
      refresh_per_bank = 1'b1;
      @(negedge clk);
      issue(3'd4, 6, 14'h0);
      check_all("R6 per-bank refresh");
      issue(3'd1, 0, 14'h0042);
      refresh_per_bank = 1'b0;
      @(negedge clk);
      issue(3'd4, 0, 14'h0);
      check_all("R7 all-bank refresh");
   endtask

   task automatic t_quiet;
      issue(3'd1, 1, 14'h2A2A);
      issue(3'd1, 4, 14'h1555);
      issue(3'd0, 1, 14'h0F0F);
      issue(3'd5, 4, 14'h0F0F);
      issue(3'd6, 1, 14'h0F0F);
      issue(3'd7, 4, 14'h0F0F);
      check_all("R8 quiet codes");
   endtask

   task automatic t_invalid;
      cmd_valid = 1'b0;
      cmd_bank = 3'd1; cmd_row = 14'h0AAA;
      for (int c = 1; c < 5; c++) begin
         cmd_code = 3'(c);
         @(negedge clk);
      end
      cmd_code = 3'd0;
      check_all("R9 strobe low");
   endtask

   task automatic t_select;
      // Closed bank with an old stored row must read zero.
      issue(3'd2, 4, 14'h0);
      check_all("R10 closed bank reads zero");
   endtask

   initial begin
      #50000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset;
      t_activate;
      t_reactivate;
      t_precharge;
      t_prea;
      t_ref;
      t_quiet;
      t_invalid;
      t_select;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule